// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that contains no multiplier. Each accepted sample is loaded in parallel into a serializer and then moves out one bit per clock, least significant bit first. The bits pass through a chain of bit-serial delay stages, one stage per tap. Each stage holds one earlier sample of the history. On every processing clock, the current low bit of each stage forms one bit of an address. That address selects a precomputed table entry holding the sum of the coefficients whose address bits are set. A scaling accumulator weights each entry by its bit position and adds it. On the sign-bit clock it subtracts the entry, so inputs are treated as two's complement.

A result takes DATA_W clocks. The filter can take one sample every DATA_W clocks. A new sample may arrive on the same clock that finishes the previous one, so samples can run back to back. The coefficients are fixed when the design is elaborated. The default set is 20, -256, 200, 255, 39, 117, -235, 47 for taps 0 to 7, where tap 0 is the newest sample.

Top module: `fir_da_serial`

## Requirements
- R1: While rst_n is low and after its release, out_valid is 0 and out_result is 0. Reset clears the sample history to zero, so the first results after reset depend only on samples accepted since reset.
- R2: The result for an accepted sample x[n] is the sum over k of c[k]*x[n-k], for taps k = 0..TAPS-1 (tap 0 is the newest). Samples are DATA_W-bit two's complement values. out_result is a two's complement value of OUT_W bits with full precision.
- R3: out_valid is high for exactly one clock. It is first seen DATA_W clocks after the clock edge that accepted the sample, and not before.
- R4: The sign bit of each sample is weighted negatively. The most negative input (-2^(DATA_W-1)) and the largest positive input (2^(DATA_W-1)-1) both give exact products.
- R5: A sample is accepted when in_valid is high and the filter is idle, or when in_valid is high on the clock that processes the last bit of the previous sample. Samples presented every DATA_W clocks therefore give one result every DATA_W clocks.
- R6: in_valid on any other clock while a sample is being processed is ignored. That sample does not enter the history and changes no result.
- R7: out_result keeps its value between out_valid pulses.
- R8: The history is kept across idle gaps of any length between samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W | Two's complement input sample |
| out_valid | output | 1 | One-clock pulse marking a new result |
| out_result | output | OUT_W | Two's complement filter result |

## Verification
Two events can fall on the same clock: the accumulator completes and subtracts the sign bit of one sample, and the serializer loads the next sample. The bench provokes this by raising in_valid on the clock before each result is due, across a stream of varied samples. It then checks every result against a multiply-accumulate model of the history. A wrong merge shows up in two ways: a dropped sample, or a history stage that shifted from the newly loaded value instead of the old one. Either would corrupt the following results.

// File: rtl/fir_da_pkg.sv
// Shared constants of the distributed-arithmetic FIR filter.
// Holds the default 8-tap coefficient set; tap 0 weights the newest sample.
package fir_da_pkg;
    localparam int REF_TAPS = 8;
    localparam int REF_COEFS [REF_TAPS] = '{20, -256, 200, 255, 39, 117, -235, 47};
endpackage

// File: rtl/da_skew_chain.sv
// Parallel-to-serial converter followed by a cascade of bit-serial delay
// stages. Stage 0 is the serializer; stage k holds the sample k steps older.
// Assumes: shift is high for exactly DATA_W clocks per accepted sample, so
// every stage passes one whole sample to its neighbour per sample period.
// A load and a shift on the same clock move the old serializer bit onward.
module da_skew_chain #(
    parameter int DATA_W = 12,
    parameter int TAPS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic [TAPS-1:0]   addr
);
    logic [DATA_W-1:0] stage [TAPS];

    // Load the serializer and shift the whole chain one bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) stage[k] <= '0;
        end else begin
            if (load)       stage[0] <= din;
            else if (shift) stage[0] <= stage[0] >> 1;
            if (shift) begin
                for (int k = 1; k < TAPS; k++)
                    stage[k] <= {stage[k-1][0], stage[k][DATA_W-1:1]};
            end
        end
    end

    // The low bit of each stage is one address bit of the table.
    always_comb begin
        for (int k = 0; k < TAPS; k++) addr[k] = stage[k][0];
    end
endmodule

// File: rtl/da_pp_table.sv
// Partial-product table: entry a holds the sum of the coefficients whose
// bit is set in a. Contents are computed at elaboration from COEFS.
// Assumes: PP_W is wide enough for the largest subset sum.
module da_pp_table #(
    parameter int TAPS = 8,
    parameter int PP_W = 13,
    parameter int COEFS [TAPS] = fir_da_pkg::REF_COEFS
) (
    input  logic [TAPS-1:0]          addr,
    output logic signed [PP_W-1:0]   pp
);
    localparam int ROWS = 2 ** TAPS;

    function automatic int subset_sum(input int sel);
        int s;
        s = 0;
        for (int k = 0; k < TAPS; k++)
            if (((sel >> k) & 1) == 1) s += COEFS[k];
        return s;
    endfunction

    logic signed [PP_W-1:0] rom [ROWS];

    for (genvar a = 0; a < ROWS; a++) begin : g_row
        localparam int SUM = subset_sum(a);
        assign rom[a] = PP_W'(SUM);
    end

    // Read the entry selected by the current column of history bits.
    assign pp = rom[addr];
endmodule

// File: rtl/da_scale_acc.sv
// Scaling accumulator: adds each table entry weighted by 2^bit_idx, and
// subtracts it on the sign-bit position. Bit 0 restarts the sum.
// Assumes: bit_idx counts 0..DATA_W-1 on consecutive step clocks.
module da_scale_acc #(
    parameter int DATA_W = 12,
    parameter int PP_W   = 13,
    parameter int OUT_W  = 25,
    parameter int CNT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic [CNT_W-1:0]        bit_idx,
    input  logic signed [PP_W-1:0]  pp,
    output logic                    res_valid,
    output logic signed [OUT_W-1:0] result
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic signed [OUT_W-1:0] acc;
    logic signed [OUT_W-1:0] base;
    logic signed [OUT_W-1:0] weighted;
    logic signed [OUT_W-1:0] next_acc;

    // Form the next partial sum from the weighted table entry.
    always_comb begin
        base     = (bit_idx == '0) ? '0 : acc;
        weighted = {{(OUT_W-PP_W){pp[PP_W-1]}}, pp} <<< bit_idx;
        next_acc = (bit_idx == LAST) ? base - weighted : base + weighted;
    end

    // Keep the running sum and publish it after the sign bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            res_valid <= 1'b0;
            result    <= '0;
        end else begin
            res_valid <= step && (bit_idx == LAST);
            if (step) acc <= next_acc;
            if (step && bit_idx == LAST) result <= next_acc;
        end
    end
endmodule

// File: rtl/fir_da_serial.sv
// Top of the bit-serial distributed-arithmetic FIR filter. Accepts a sample
// when idle or on the last bit clock of the previous one, then runs DATA_W
// bit clocks through the skew chain, table and scaling accumulator.
// Assumes: coefficients fit COEF_W bits signed; in_valid while busy on other
// clocks is dropped.
module fir_da_serial #(
    parameter int DATA_W = 12,
    parameter int TAPS   = 8,
    parameter int COEF_W = 10,
    parameter int COEFS [TAPS] = fir_da_pkg::REF_COEFS,
    localparam int PP_W  = COEF_W + $clog2(TAPS),
    localparam int OUT_W = PP_W + DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_sample,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_result
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic             busy;
    logic [CNT_W-1:0] bit_cnt;
    logic             last_bit;
    logic             accept;
    logic [TAPS-1:0]  addr;
    logic signed [PP_W-1:0] pp;

    assign last_bit = busy && (bit_cnt == LAST);
    assign accept   = in_valid && (!busy || last_bit);

    // Sequence the DATA_W bit clocks of each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            bit_cnt <= '0;
        end else if (last_bit) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
        end else if (busy) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    da_skew_chain #(.DATA_W(DATA_W), .TAPS(TAPS)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift (busy),
        .din   (in_sample),
        .addr  (addr)
    );

    da_pp_table #(.TAPS(TAPS), .PP_W(PP_W), .COEFS(COEFS)) u_table (
        .addr (addr),
        .pp   (pp)
    );

    da_scale_acc #(.DATA_W(DATA_W), .PP_W(PP_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (busy),
        .bit_idx   (bit_cnt),
        .pp        (pp),
        .res_valid (out_valid),
        .result    (out_result)
    );
endmodule

// File: rtl/fir_da_serial_chk.sv
// Checker for the bit-serial FIR filter, bound to every instance of the top.
// Relates the sequencing state to the strobes and the result register.
module fir_da_serial_chk #(
    parameter int DATA_W = 12,
    parameter int OUT_W  = 25,
    parameter int CNT_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             busy,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_result
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    // R3: a result strobe lasts one clock
    assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3: a result strobe follows the last bit clock
    assert_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(busy) && $past(bit_cnt) == LAST));

    // R5: an accepted strobe starts bit 0 on the next clock
    assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!busy || bit_cnt == LAST)) |=> (busy && bit_cnt == '0));

    // R6: a strobe mid-sample cannot restart the bit sequence
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_cnt != LAST) |=> (busy && bit_cnt == $past(bit_cnt) + 1'b1));

    // R7: the result only changes with its strobe
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_result));
endmodule

bind fir_da_serial fir_da_serial_chk #(
    .DATA_W (DATA_W),
    .OUT_W  (OUT_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .busy       (busy),
    .bit_cnt    (bit_cnt),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/fir_da_serial_test.sv
// Directed bench for the bit-serial FIR filter against a multiply-accumulate model.
module fir_da_serial_test;
    localparam int B     = 12;
    localparam int TAPS  = 8;
    localparam int OUT_W = 10 + 3 + B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [B-1:0] in_sample = '0;
    logic out_valid;
    logic signed [OUT_W-1:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int hist [TAPS];

    fir_da_serial uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int v);
        for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = v;
    endtask

    function automatic longint model_y();
        longint s = 0;
        for (int k = 0; k < TAPS; k++) s += longint'(fir_da_pkg::REF_COEFS[k]) * hist[k];
        return s;
    endfunction

    // R1: reset state and cleared history
    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        rst_n = 1'b1;
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_result == '0, "R1 after reset", out_result, 0);
    endtask

    // Send one sample from a negedge; checks latency (R3), hold (R7), value (R2)
    task automatic send_one(input int v, input string req);
        logic signed [OUT_W-1:0] prev;
        bit quiet;
        longint e;
        prev = out_result;
        in_valid = 1'b1;
        in_sample = B'(v);
        push(v);
        e = model_y();
        quiet = 1'b1;
        for (int k = 1; k <= B; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (out_valid || out_result != prev) quiet = 1'b0;
        end
        chk(quiet, "R3 R7 quiet before result", out_result, prev);
        @(negedge clk);
        chk(out_valid == 1'b1, "R3 strobe at DATA_W clocks", out_valid, 1);
        chk(longint'(out_result) == e, req, out_result, e);
        @(negedge clk);
        chk(out_valid == 1'b0, "R3 single clock strobe", out_valid, 0);
    endtask

    // R2 R8: impulse returns each coefficient in turn
    task automatic t_impulse();
        send_one(1, "R2 impulse tap 0");
        for (int k = 1; k < TAPS; k++) send_one(0, "R2 impulse tail");
        send_one(0, "R2 impulse flushed");
    endtask

    // R4: extreme inputs
    task automatic t_extremes();
        send_one(-(1 << (B - 1)), "R4 most negative");
        send_one((1 << (B - 1)) - 1, "R4 most positive");
        send_one(-1, "R4 minus one");
        send_one(-(1 << (B - 1)), "R4 most negative again");
    endtask

    // R5: back-to-back samples, load on the final bit clock
    task automatic t_stream(input int n, input int seed);
        longint exp_q [$];
        int s = seed;
        for (int i = 0; i < n; i++) begin
            int v;
            s = s * 1103515245 + 12345;
            v = (s >>> 8) % (1 << (B - 1));
            in_valid = 1'b1;
            in_sample = B'(v);
            push(v);
            exp_q.push_back(model_y());
            @(negedge clk);
            in_valid = 1'b0;
            if (i > 0) begin
                longint e = exp_q.pop_front();
                chk(out_valid == 1'b1 && longint'(out_result) == e,
                    "R5 back-to-back result", out_result, e);
            end
            repeat (B - 1) @(negedge clk);
        end
        @(negedge clk);
        begin
            longint e = exp_q.pop_front();
            chk(out_valid == 1'b1 && longint'(out_result) == e,
                "R5 last of stream", out_result, e);
        end
        @(negedge clk);
    endtask

    // R6: strobe mid-sample is dropped
    task automatic t_ignore();
        longint e;
        in_valid = 1'b1;
        in_sample = B'(300);
        push(300);
        e = model_y();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = B'(-777);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (B - 3) @(negedge clk);
        chk(out_valid == 1'b1 && longint'(out_result) == e, "R6 result unaffected", out_result, e);
        @(negedge clk);
        send_one(5, "R6 history unaffected");
    endtask

    // R8: long idle gap keeps history
    task automatic t_gap();
        send_one(-1000, "R8 before gap");
        repeat (50) @(negedge clk);
        send_one(17, "R8 after gap");
        repeat (7) @(negedge clk);
        send_one(0, "R8 after short gap");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_impulse();
        t_extremes();
        t_stream(20, 7);
        t_ignore();
        t_gap();
        t_reset();
        send_one(3, "R1 history cleared");
        send_one(0, "R1 history cleared tap 1");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule